// File: doc/BRIEF.md
# Soft-Error Reload Sequencer

This block sits behind a configuration-memory integrity checker. Each cycle in which the checker raises its error input is one detected upset. When the sequencer is idle, it counts the upset and sets a sticky error flag. A mode input selects what happens next. In automatic mode the sequencer asks the configuration engine for a full reload from external flash. In report-only mode it leaves the reload decision to the host.

A reload is requested by driving an active-low program line low for a fixed number of cycles and then releasing it. The rising edge of the line starts the reload. The sequencer then waits for the engine's done line to drop, which shows the reload has begun. After that it waits for done to return high, which shows the reload succeeded. Each wait has its own timeout. Missing either one marks the reload as failed.

The host sees sticky success and failure flags, a busy indication, and saturating counters of upsets and of successful reloads. The host clears the flags with an acknowledge input.

Top module: `seu_reload_seq`

## Requirements
- R1: In a cycle where the sequencer is idle and `err_evt_i` is high, one upset is taken. From the next cycle `err_flag_o` is 1 and `err_cnt_o` has grown by one.
- R2: An upset taken with `auto_mode_i`=0 leaves `prog_n_o` high and `busy_o` low.
- R3: An upset taken with `auto_mode_i`=1 drives `prog_n_o` low from the next cycle for exactly PULSE_CYC cycles, after which it returns high.
- R4: After the program line is released, if `cfg_done_i` goes low and later high again, `reload_ok_o` is set and `ok_cnt_o` grows by one.
- R5: If `cfg_done_i` stays high for FALL_TMO cycles after the release, `reload_fail_o` is set and the sequencer returns to idle.
- R6: If `cfg_done_i` stays low for RISE_TMO cycles after it fell, `reload_fail_o` is set and the sequencer returns to idle.
- R7: `busy_o` is high from the first low cycle of the program line until the reload outcome is decided. While it is high, `err_evt_i` is ignored: it is not counted and it does not restart the sequence.
- R8: `err_cnt_o` is 8 bits wide and saturates at 255.
- R9: `ok_cnt_o` is 8 bits wide and saturates at 255.
- R10: While reset is active (`rst_n`=0), `prog_n_o` is 1 and all flags, counters and `busy_o` are 0.
- R11: `ack_i` clears `err_flag_o`, `reload_ok_o` and `reload_fail_o` on the next cycle and leaves the counters unchanged. A flag that is being set in the same cycle as `ack_i` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| err_evt_i | input | 1 | Upset indication from the integrity checker, one event per high cycle |
| auto_mode_i | input | 1 | 1: reload automatically, 0: report only |
| ack_i | input | 1 | Host acknowledge, clears the status flags |
| cfg_done_i | input | 1 | Configuration engine done status |
| prog_n_o | output | 1 | Active-low program request; its rising edge starts a reload |
| busy_o | output | 1 | Reload sequence in progress |
| err_flag_o | output | 1 | Sticky: an upset was taken |
| reload_ok_o | output | 1 | Sticky: a reload completed |
| reload_fail_o | output | 1 | Sticky: a reload timed out |
| err_cnt_o | output | 8 | Saturating count of taken upsets |
| ok_cnt_o | output | 8 | Saturating count of successful reloads |

## Verification
The bench drives upsets into a reload that is already running. A design that did not filter them would count extra upsets or stretch the program pulse.

It also runs an engine that never drops done and an engine that never raises it again. A design that waits forever, or that reports success when done never fell, would miss the failure flag.

Acknowledge is pulsed in the same cycle as a new upset. A design that gave the clear priority would lose the event.

Both counters are pushed well past 255. Any wrap back to zero would show up as a count mismatch.

// File: rtl/seu_pkg.sv
// Shared types for the soft-error reload sequencer.
// Assumes nothing beyond a two-bit state encoding.
package seu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_WFALL = 2'd2,
        ST_WRISE = 2'd3
    } seq_st_t;
endpackage

// File: rtl/seu_sat_cnt.sv
// Saturating up-counter: adds one per cycle with inc high and holds at all-ones.
// Assumes synchronous active-low reset.
module seu_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Count up, stopping at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && (count != {W{1'b1}}))
            count <= count + 1'b1;
    end
endmodule

// File: rtl/seu_step_tmr.sv
// Cycle timer for the current sequencer phase: cleared by clr, otherwise counts up
// and holds at its maximum. Assumes W is wide enough for the longest window.
module seu_step_tmr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);
    // Restart on phase change, otherwise advance without wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count <= '0;
        else if (count != {W{1'b1}})
            count <= count + 1'b1;
    end
endmodule

// File: rtl/seu_reload_seq.sv
// Soft-error reload sequencer. It takes upset events while idle and then either
// reports them or drives a program pulse and watches done fall and rise again,
// each step bounded by a timeout. Assumes cfg_done_i is synchronous to clk and
// err_evt_i marks one event per high cycle.
module seu_reload_seq #(
    parameter int PULSE_CYC = 4,
    parameter int FALL_TMO  = 8,
    parameter int RISE_TMO  = 16,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_evt_i,
    input  logic             auto_mode_i,
    input  logic             ack_i,
    input  logic             cfg_done_i,
    output logic             prog_n_o,
    output logic             busy_o,
    output logic             err_flag_o,
    output logic             reload_ok_o,
    output logic             reload_fail_o,
    output logic [CNT_W-1:0] err_cnt_o,
    output logic [CNT_W-1:0] ok_cnt_o
);
    import seu_pkg::*;

    localparam int MAX_A = (PULSE_CYC > FALL_TMO) ? PULSE_CYC : FALL_TMO;
    localparam int MAX_W = (MAX_A > RISE_TMO) ? MAX_A : RISE_TMO;
    localparam int TW    = $clog2(MAX_W + 1);
    localparam logic [TW-1:0] PULSE_LAST = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] FALL_LAST  = TW'(FALL_TMO - 1);
    localparam logic [TW-1:0] RISE_LAST  = TW'(RISE_TMO - 1);

    seq_st_t       state, nxt;
    logic [TW-1:0] tmr;
    logic          take_evt, set_ok, set_fail, tmr_clr;

    // An upset is only taken while no reload is running.
    assign take_evt = (state == ST_IDLE) && err_evt_i;
    assign tmr_clr  = (nxt != state);

    // Next-state and outcome decode.
    always_comb begin
        nxt      = state;
        set_ok   = 1'b0;
        set_fail = 1'b0;
        unique case (state)
            ST_IDLE:  if (take_evt && auto_mode_i) nxt = ST_PULSE;
            ST_PULSE: if (tmr == PULSE_LAST) nxt = ST_WFALL;
            ST_WFALL: begin
                if (!cfg_done_i) begin
                    nxt = ST_WRISE;
                end else if (tmr == FALL_LAST) begin
                    nxt      = ST_IDLE;
                    set_fail = 1'b1;
                end
            end
            ST_WRISE: begin
                if (cfg_done_i) begin
                    nxt    = ST_IDLE;
                    set_ok = 1'b1;
                end else if (tmr == RISE_LAST) begin
                    nxt      = ST_IDLE;
                    set_fail = 1'b1;
                end
            end
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // Sticky status flags; a set in the same cycle wins over the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag_o    <= 1'b0;
            reload_ok_o   <= 1'b0;
            reload_fail_o <= 1'b0;
        end else begin
            err_flag_o    <= take_evt | (err_flag_o    & ~ack_i);
            reload_ok_o   <= set_ok   | (reload_ok_o   & ~ack_i);
            reload_fail_o <= set_fail | (reload_fail_o & ~ack_i);
        end
    end

    seu_step_tmr #(.W(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .count (tmr)
    );

    seu_sat_cnt #(.W(CNT_W)) u_err_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (take_evt),
        .count (err_cnt_o)
    );

    seu_sat_cnt #(.W(CNT_W)) u_ok_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (set_ok),
        .count (ok_cnt_o)
    );

    assign prog_n_o = (state != ST_PULSE);
    assign busy_o   = (state != ST_IDLE);
endmodule

// File: rtl/seu_reload_seq_chk.sv
// Property checker for the reload sequencer, bound to every instance.
// Assumes the same parameters as the instance it watches.
module seu_reload_seq_chk #(
    parameter int PULSE_CYC = 4,
    parameter int CNT_W     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             err_evt_i,
    input logic             auto_mode_i,
    input logic             ack_i,
    input logic             prog_n_o,
    input logic             busy_o,
    input logic             reload_ok_o,
    input logic             reload_fail_o,
    input logic [CNT_W-1:0] err_cnt_o,
    input logic [CNT_W-1:0] ok_cnt_o
);
    logic [31:0] low_run;

    // Length of the current low stretch of the program line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_run <= '0;
        else if (!prog_n_o)
            low_run <= low_run + 1;
        else
            low_run <= '0;
    end

    assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_n_o) |-> (low_run == PULSE_CYC));

    assert_report_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && err_evt_i && !auto_mode_i) |=> (!busy_o && prog_n_o));

    assert_take_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && err_evt_i && (err_cnt_o != {CNT_W{1'b1}}))
            |=> (err_cnt_o == $past(err_cnt_o) + 1'b1));

    assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && err_evt_i) |=> $stable(err_cnt_o));

    assert_err_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt_o == {CNT_W{1'b1}}) |=> (err_cnt_o == {CNT_W{1'b1}}));

    assert_ok_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_cnt_o == {CNT_W{1'b1}}) |=> (ok_cnt_o == {CNT_W{1'b1}}));

    assert_ack_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !busy_o) |=> (!reload_ok_o && !reload_fail_o));

    assert_fail_from_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reload_fail_o) |-> $past(busy_o));
endmodule

bind seu_reload_seq seu_reload_seq_chk #(
    .PULSE_CYC (PULSE_CYC),
    .CNT_W     (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .err_evt_i     (err_evt_i),
    .auto_mode_i   (auto_mode_i),
    .ack_i         (ack_i),
    .prog_n_o      (prog_n_o),
    .busy_o        (busy_o),
    .reload_ok_o   (reload_ok_o),
    .reload_fail_o (reload_fail_o),
    .err_cnt_o     (err_cnt_o),
    .ok_cnt_o      (ok_cnt_o)
);

// File: tb/test_seu_reload_seq.sv
// Bench for the reload sequencer: configuration engine model, behavioural
// reference model, comparison on every falling edge, directed scenarios.
module test_seu_reload_seq;
    localparam int CLK_PER   = 10;
    localparam int PULSE_CYC = 4;
    localparam int FALL_TMO  = 8;
    localparam int RISE_TMO  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic err_evt = 1'b0, auto_mode = 1'b0, ack = 1'b0, cfg_done = 1'b1;
    logic prog_n, busy, err_flag, rl_ok, rl_fail;
    logic [7:0] err_cnt, ok_cnt;

    int n_chk = 0, n_err = 0;

    always #(CLK_PER/2) clk = ~clk;

    seu_reload_seq #(.PULSE_CYC(PULSE_CYC), .FALL_TMO(FALL_TMO),
                     .RISE_TMO(RISE_TMO), .CNT_W(8)) i_seu_reload_seq (
        .clk(clk), .rst_n(rst_n), .err_evt_i(err_evt), .auto_mode_i(auto_mode),
        .ack_i(ack), .cfg_done_i(cfg_done), .prog_n_o(prog_n), .busy_o(busy),
        .err_flag_o(err_flag), .reload_ok_o(rl_ok), .reload_fail_o(rl_fail),
        .err_cnt_o(err_cnt), .ok_cnt_o(ok_cnt));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Configuration engine model: the delays are counted in cycles; 0 means never.
    int eng_fall = 2, eng_rise = 3, eng_ph = 0, eng_n = 0;
    bit eng_force_hi = 1'b0, prev_prog = 1'b1;
    always @(negedge clk) begin
        if (eng_force_hi) begin
            cfg_done = 1'b1;
            eng_ph   = 0;
        end else if (prog_n && !prev_prog) begin
            eng_ph = 1;
            eng_n  = 0;
        end else if (eng_ph == 1) begin
            eng_n++;
            if (eng_fall > 0 && eng_n >= eng_fall) begin
                cfg_done = 1'b0; eng_ph = 2; eng_n = 0;
            end
        end else if (eng_ph == 2) begin
            eng_n++;
            if (eng_rise > 0 && eng_n >= eng_rise) begin
                cfg_done = 1'b1; eng_ph = 0;
            end
        end
        prev_prog = prog_n;
    end

    // Reference model, advanced at each rising edge.
    int m_phase = 0, m_t = 0, m_ecnt = 0, m_okcnt = 0;
    bit m_eflag = 0, m_ok = 0, m_fail = 0;
    always @(posedge clk) begin
        bit se, so, sf;
        se = 0; so = 0; sf = 0;
        if (!rst_n) begin
            m_phase = 0; m_t = 0; m_ecnt = 0; m_okcnt = 0;
            m_eflag = 0; m_ok = 0; m_fail = 0;
        end else begin
            case (m_phase)
                0: if (err_evt) begin
                       se = 1;
                       if (m_ecnt < 255) m_ecnt++;
                       if (auto_mode) begin m_phase = 1; m_t = 0; end
                   end
                1: if (m_t == PULSE_CYC - 1) begin m_phase = 2; m_t = 0; end
                   else m_t++;
                2: if (!cfg_done) begin m_phase = 3; m_t = 0; end
                   else if (m_t == FALL_TMO - 1) begin sf = 1; m_phase = 0; end
                   else m_t++;
                default: if (cfg_done) begin
                             so = 1; m_phase = 0;
                             if (m_okcnt < 255) m_okcnt++;
                         end else if (m_t == RISE_TMO - 1) begin sf = 1; m_phase = 0; end
                         else m_t++;
            endcase
            if (ack) begin m_eflag = 0; m_ok = 0; m_fail = 0; end
            if (se) m_eflag = 1;
            if (so) m_ok = 1;
            if (sf) m_fail = 1;
        end
    end

    // Cycle-by-cycle comparison against the reference model.
    bit cmp_on = 1'b0;
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R3 prog_n", int'(prog_n), int'(m_phase != 1));
            check("R7 busy", int'(busy), int'(m_phase != 0));
            check("R1 err_flag", int'(err_flag), int'(m_eflag));
            check("R4 reload_ok", int'(rl_ok), int'(m_ok));
            check("R5/R6 reload_fail", int'(rl_fail), int'(m_fail));
            check("R8 err_cnt", int'(err_cnt), m_ecnt);
            check("R9 ok_cnt", int'(ok_cnt), m_okcnt);
        end
    end

    task automatic fire(input bit a);
        @(negedge clk); err_evt = 1'b1; auto_mode = a;
        @(negedge clk); err_evt = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values
        check("R10 prog_n", int'(prog_n), 1);
        check("R10 busy", int'(busy), 0);
        check("R10 flags", int'({err_flag, rl_ok, rl_fail}), 0);
        check("R10 counts", int'(err_cnt) + int'(ok_cnt), 0);
        cmp_on = 1'b1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: a report-only event counts but does not reload
        fire(1'b0);
        repeat (6) @(negedge clk);
        check("R2 no pulse", int'(prog_n), 1);
        check("R1 counted", int'(err_cnt), 1);

        // R11: acknowledge clears the flags and keeps the counts
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        check("R11 cleared", int'(err_flag), 0);
        check("R11 count kept", int'(err_cnt), 1);

        // R3/R4: an automatic reload that succeeds
        eng_fall = 2; eng_rise = 3;
        fire(1'b1);
        wait_idle();
        check("R4 ok", int'(rl_ok), 1);

        // R7: events during a reload are ignored
        @(negedge clk); err_evt = 1'b1; auto_mode = 1'b1;
        @(negedge clk); err_evt = 1'b0;
        repeat (2) @(negedge clk); err_evt = 1'b1;
        repeat (3) @(negedge clk); err_evt = 1'b0;
        wait_idle();
        check("R7 ignored", int'(err_cnt), 3);

        // R5: done never falls
        eng_fall = 0;
        fire(1'b1);
        wait_idle();
        check("R5 fail", int'(rl_fail), 1);

        // R6: done falls but never rises
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        eng_fall = 2; eng_rise = 0;
        fire(1'b1);
        wait_idle();
        check("R6 fail", int'(rl_fail), 1);
        eng_force_hi = 1'b1;
        repeat (2) @(negedge clk);
        eng_force_hi = 1'b0;

        // R11: a set in the same cycle as the acknowledge wins
        @(negedge clk); ack = 1'b1; err_evt = 1'b1; auto_mode = 1'b0;
        @(negedge clk); ack = 1'b0; err_evt = 1'b0;
        check("R11 set wins", int'(err_flag), 1);

        // R8: the upset counter saturates
        @(negedge clk); err_evt = 1'b1; auto_mode = 1'b0;
        repeat (260) @(negedge clk);
        err_evt = 1'b0;
        @(negedge clk);
        check("R8 saturated", int'(err_cnt), 255);

        // R9: the reload counter saturates
        eng_fall = 1; eng_rise = 1;
        for (int k = 0; k < 258; k++) begin
            fire(1'b1);
            wait_idle();
        end
        check("R9 saturated", int'(ok_cnt), 255);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule